// File: doc/BRIEF.md
# Word Access Address Generator

This block forms the byte address for word-sized loads and stores in an integer pipeline and decides whether the base register is rewritten for the updating forms. Two address modes exist: base plus a sign-extended 16-bit displacement, and base plus a second register value. For the non-updating forms, a base register index of zero stands for the constant zero rather than the contents of register zero. An updating form rewrites the base register with the address it computed.

Some operand combinations cannot be encoded legally. An updating access whose base index is zero is illegal. An updating load whose base index equals its destination index is also illegal. When an access is illegal, the block raises a flag and suppresses the base rewrite. A second flag marks an address that does not fall on a 4-byte boundary. Every output is registered and appears one cycle after the request.

Top module: `wea_gen`

## Requirements
- R1: After reset, out_vld, wb_en, bad_form and misalign are 0 and ea is 0.
- R2: When in_vld is high at a clock edge, out_vld is high in the next cycle, and the other outputs in that cycle describe that request. When in_vld is low, out_vld is low in the next cycle and wb_en is 0.
- R3: With mode_idx=0 (offset mode), ea is the base value plus the 16-bit displacement sign-extended to 32 bits, modulo 2^32.
- R4: With mode_idx=1 (indexed mode), ea is the base value plus idx_val, modulo 2^32.
- R5: For a non-updating access with base_idx=0, the base operand is zero in both modes, whatever base_val holds.
- R6: For an updating access (upd=1), the base operand is base_val even when base_idx is 0.
- R7: A legal updating access drives wb_en=1, with wb_idx equal to base_idx and wb_val equal to ea.
- R8: An updating store (is_load=0) with base_idx=0 drives bad_form=1.
- R9: An updating load (is_load=1) drives bad_form=1 when base_idx is 0 or when base_idx equals rt_idx.
- R10: Whenever bad_form is 1, wb_en is 0. A non-updating access never drives bad_form or wb_en.
- R11: misalign is 1 exactly when ea[1:0] is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request valid |
| mode_idx | input | 1 | 0 selects offset mode, 1 selects indexed mode |
| upd | input | 1 | Updating form |
| is_load | input | 1 | 1 for a load, 0 for a store |
| base_idx | input | 5 | Base register index |
| base_val | input | 32 | Base register contents |
| rt_idx | input | 5 | Destination index (load) or source index (store) |
| disp | input | 16 | Signed displacement |
| idx_val | input | 32 | Index register contents |
| out_vld | output | 1 | Result valid |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base rewrite enable |
| wb_idx | output | 5 | Register index to rewrite |
| wb_val | output | 32 | Value to rewrite |
| bad_form | output | 1 | Illegal operand combination |
| misalign | output | 1 | Address is not word aligned |

## Verification
The hardest case to reach is base index zero combined with a nonzero base value. It must be reached in three ways: as a non-updating access, where the value is ignored, as an updating store, and as an updating load, where the value is used but the access is flagged illegal. The vector table drives base_idx=0 with a nonzero base_val under every pairing of mode and update, so that a lost zero substitution changes ea. A separate directed vector sets base_idx equal to rt_idx on both a store and a load, and confirms that only the load raises the illegal flag. Negative displacements that wrap past zero cover sign extension and the carry out of the top bit.

// File: rtl/wea_pkg.sv
package wea_pkg;
    localparam int XLEN  = 32;
    localparam int RIDXW = 5;
    localparam int DISPW = 16;
    localparam int ALIGNB = 2;

    typedef struct packed {
        logic             vld;
        logic [XLEN-1:0]  ea;
        logic             wb_en;
        logic [RIDXW-1:0] wb_idx;
        logic [XLEN-1:0]  wb_val;
        logic             bad;
        logic             mis;
    } wea_out_t;
endpackage

// File: rtl/wea_operand.sv
module wea_operand #(
    parameter int XLEN  = 32,
    parameter int RIDXW = 5,
    parameter int DISPW = 16
) (
    input  logic             mode_idx,
    input  logic             upd,
    input  logic [RIDXW-1:0] base_idx,
    input  logic [XLEN-1:0]  base_val,
    input  logic [DISPW-1:0] disp,
    input  logic [XLEN-1:0]  idx_val,
    output logic [XLEN-1:0]  sum
);
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;

    always_comb begin
        // register zero reads as literal zero unless updating
        if (!upd && base_idx == '0) opa = '0;
        else                        opa = base_val;
        if (mode_idx) opb = idx_val;
        else          opb = {{(XLEN-DISPW){disp[DISPW-1]}}, disp};
        sum = opa + opb;
    end
endmodule

// File: rtl/wea_legal.sv
module wea_legal #(
    parameter int RIDXW = 5
) (
    input  logic             upd,
    input  logic             is_load,
    input  logic [RIDXW-1:0] base_idx,
    input  logic [RIDXW-1:0] rt_idx,
    output logic             bad
);
    logic zero_base;
    logic same_reg;

    always_comb begin
        zero_base = (base_idx == '0);
        same_reg  = (base_idx == rt_idx);
        bad       = upd && (zero_base || (is_load && same_reg));
    end
endmodule

// File: rtl/wea_gen.sv
module wea_gen
    import wea_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             mode_idx,
    input  logic             upd,
    input  logic             is_load,
    input  logic [RIDXW-1:0] base_idx,
    input  logic [XLEN-1:0]  base_val,
    input  logic [RIDXW-1:0] rt_idx,
    input  logic [DISPW-1:0] disp,
    input  logic [XLEN-1:0]  idx_val,
    output logic             out_vld,
    output logic [XLEN-1:0]  ea,
    output logic             wb_en,
    output logic [RIDXW-1:0] wb_idx,
    output logic [XLEN-1:0]  wb_val,
    output logic             bad_form,
    output logic             misalign
);
    logic [XLEN-1:0] sum;
    logic            bad;
    wea_out_t        st_d;
    wea_out_t        st_q;

    wea_operand #(.XLEN(XLEN), .RIDXW(RIDXW), .DISPW(DISPW)) u_opnd (
        .mode_idx (mode_idx),
        .upd      (upd),
        .base_idx (base_idx),
        .base_val (base_val),
        .disp     (disp),
        .idx_val  (idx_val),
        .sum      (sum)
    );

    wea_legal #(.RIDXW(RIDXW)) u_legal (
        .upd      (upd),
        .is_load  (is_load),
        .base_idx (base_idx),
        .rt_idx   (rt_idx),
        .bad      (bad)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = in_vld;
        st_d.wb_en  = 1'b0;
        if (in_vld) begin
            st_d.ea     = sum;
            st_d.bad    = bad;
            st_d.wb_en  = upd && !bad;
            st_d.wb_idx = base_idx;
            st_d.wb_val = sum;
            st_d.mis    = (sum[ALIGNB-1:0] != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign ea       = st_q.ea;
    assign wb_en    = st_q.wb_en;
    assign wb_idx   = st_q.wb_idx;
    assign wb_val   = st_q.wb_val;
    assign bad_form = st_q.bad;
    assign misalign = st_q.mis;
endmodule

// File: rtl/wea_gen_chk.sv
module wea_gen_chk
    import wea_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             upd,
    input logic             is_load,
    input logic [RIDXW-1:0] base_idx,
    input logic [RIDXW-1:0] rt_idx,
    input logic             out_vld,
    input logic [XLEN-1:0]  ea,
    input logic             wb_en,
    input logic [RIDXW-1:0] wb_idx,
    input logic [XLEN-1:0]  wb_val,
    input logic             bad_form,
    input logic             misalign
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r2_idle_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && !wb_en));
    a_r7_wb_matches: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_val == ea));
    a_r8_store_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && upd && !is_load && base_idx == '0) |=> bad_form);
    a_r9_load_same: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && upd && is_load && base_idx == rt_idx) |=> bad_form);
    a_r10_bad_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> !wb_en);
    a_r10_noupd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !upd) |=> (!bad_form && !wb_en));
    a_r11_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (misalign == (ea[1:0] != 2'b00)));
endmodule

bind wea_gen wea_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .upd(upd), .is_load(is_load),
    .base_idx(base_idx), .rt_idx(rt_idx), .out_vld(out_vld), .ea(ea),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val), .bad_form(bad_form),
    .misalign(misalign)
);

// File: tb/wea_gen_test.sv
module wea_gen_test;
    localparam int CLK_PER = 10;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0, mode_idx = 1'b0, upd = 1'b0, is_load = 1'b0;
    logic [4:0]  base_idx = '0, rt_idx = '0, wb_idx;
    logic [31:0] base_val = '0, idx_val = '0, ea, wb_val;
    logic [15:0] disp = '0;
    logic        out_vld, wb_en, bad_form, misalign;
    int          errs = 0, checks = 0;

    always #(CLK_PER/2) clk = ~clk;

    wea_gen uut (.*);

    // mode, upd, load, bidx, bval, ridx, disp, ival
    typedef struct packed {
        logic m; logic u; logic l;
        logic [4:0] bi; logic [31:0] bv; logic [4:0] ri;
        logic [15:0] d; logic [31:0] iv;
    } vec_t;

    localparam vec_t VT [NV] = '{
        '{1'b0,1'b0,1'b1,5'd1, 32'h0000_1000,5'd3,16'h0008,32'h0},
        '{1'b0,1'b0,1'b1,5'd1, 32'h0000_1000,5'd3,16'hFFF0,32'h0},
        '{1'b0,1'b0,1'b0,5'd0, 32'hDEAD_BEE0,5'd3,16'h0010,32'h0},
        '{1'b1,1'b0,1'b1,5'd0, 32'h1234_5670,5'd4,16'h0,32'h0000_0044},
        '{1'b1,1'b0,1'b1,5'd7, 32'h8000_0000,5'd4,16'h0,32'h8000_0004},
        '{1'b0,1'b1,1'b1,5'd1, 32'h0000_2000,5'd3,16'h0008,32'h0},
        '{1'b0,1'b1,1'b0,5'd1, 32'h0000_2000,5'd3,16'hFFF0,32'h0},
        '{1'b0,1'b1,1'b0,5'd0, 32'h0000_3000,5'd3,16'h0004,32'h0},
        '{1'b1,1'b1,1'b1,5'd0, 32'h0000_3000,5'd3,16'h0,32'h0000_0010},
        '{1'b0,1'b1,1'b1,5'd5, 32'h0000_4000,5'd5,16'h0004,32'h0},
        '{1'b0,1'b1,1'b0,5'd5, 32'h0000_4000,5'd5,16'h0004,32'h0},
        '{1'b1,1'b1,1'b0,5'd9, 32'h0000_0100,5'd2,16'h0,32'h0000_0003},
        '{1'b0,1'b0,1'b1,5'd2, 32'h0000_0004,5'd1,16'h8000,32'h0},
        '{1'b0,1'b0,1'b1,5'd2, 32'h0000_0000,5'd1,16'h0002,32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        in_vld = 1'b1; mode_idx = v.m; upd = v.u; is_load = v.l;
        base_idx = v.bi; base_val = v.bv; rt_idx = v.ri; disp = v.d; idx_val = v.iv;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    initial begin
        #(CLK_PER*5000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_vld", {31'b0,out_vld}, 0);
        chk("R1 wb_en", {31'b0,wb_en}, 0);
        chk("R1 bad_form", {31'b0,bad_form}, 0);
        chk("R1 misalign", {31'b0,misalign}, 0);
        chk("R1 ea", ea, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] a, b, e;
            logic bad;
            vec_t v = VT[i];
            a = (!v.u && v.bi == 0) ? 32'h0 : v.bv;            // R5 R6
            b = v.m ? v.iv : {{16{v.d[15]}}, v.d};              // R3 R4
            e = a + b;
            bad = v.u && (v.bi == 0 || (v.l && v.bi == v.ri));  // R8 R9
            drive(v);
            chk("R2 out_vld", {31'b0,out_vld}, 1);
            chk("R3/R4/R5/R6 ea", ea, e);
            chk("R8/R9 bad_form", {31'b0,bad_form}, {31'b0,bad});
            chk("R7/R10 wb_en", {31'b0,wb_en}, {31'b0,(v.u && !bad)});
            if (v.u && !bad) begin
                chk("R7 wb_idx", {27'b0,wb_idx}, {27'b0,v.bi});
                chk("R7 wb_val", wb_val, e);
            end
            chk("R11 misalign", {31'b0,misalign}, {31'b0,(e[1:0] != 0)});
        end

        @(negedge clk);
        chk("R2 idle out_vld", {31'b0,out_vld}, 0);
        chk("R2 idle wb_en", {31'b0,wb_en}, 0);

        drive('{1'b0,1'b1,1'b1,5'd6,32'h0000_0FFC,5'd1,16'h0004,32'h0});
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears wb_en", {31'b0,wb_en}, 0);
        chk("R1 reset clears ea", ea, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule